// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block runs the sequential word-programming mode of a serial flash slave. A command framer hands it one decoded frame each time chip-select goes high. A frame holds an opcode, a flag saying whether an address was received, a 24-bit address, a count of data bytes, and the first two data bytes. The block holds the write-enable latch and a mode flag. It also tracks the current word address across frames and turns each accepted frame into two single-byte program requests for the memory back end.

The first frame opens the mode. It carries the opcode ADh, an address and two data bytes, and it is accepted only when write-enable is set. Each later frame carries ADh and two data bytes and no address. The first byte of a frame goes to the word address with bit 0 cleared, and the second byte goes to the same word with bit 0 set. The word address then moves up by two. Write-disable ends the mode. While the mode is active, the data-out pin can be made to show ready/busy, and two opcodes switch this on and off. The time the array takes to program is represented only by the `mem_busy` input.

Top module: `aai_word_prog_seq`

## Requirements
- R1: After reset, `aai_active`, `wel`, `prog_valid` and `so_oe` are 0, and the ready/busy indication is off.
- R2: Outside the mode, opcode 06h sets `wel` and opcode 04h clears it.
- R3: An ADh frame with `frm_has_addr`=1 and `frm_nbytes`=2 enters the mode only while `wel`=1. With `wel`=0 it causes no request and no mode change.
- R4: The cycle after an accepted frame strobe, `prog_valid`=1 with `prog_addr` = word address (bit 0 = 0) and `prog_data` = `frm_byte0`. The next cycle, `prog_addr` = the same word with bit 0 = 1 and `prog_data` = `frm_byte1`. The cycle after that, `prog_valid`=0.
- R5: Each accepted frame advances the word address by 2, wrapping modulo 2^24. A frame in the mode uses the tracked address and ignores any address it carries.
- R6: An ADh frame that arrives while `mem_busy`=1, or while the two requests of the previous frame are still going out, is ignored: no request is issued and the address does not advance.
- R7: While the mode is active, every opcode other than ADh, 04h, 05h, 70h and 80h is ignored. Opcode 05h changes no state.
- R8: Opcode 04h during the mode leaves the mode and clears `wel`. After that, an ADh frame without an address causes no request.
- R9: Opcode 70h switches the ready/busy indication on and opcode 80h switches it off.
- R10: `so_oe`=1 exactly when the indication is on, the mode is active, `cs_n`=0 and `rd_active`=0. `so_val` is 1 when ready and 0 when `mem_busy`=1.
- R11: An ADh frame whose `frm_nbytes` is not 2 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| rd_active | input | 1 | A read stream currently owns the data-out pin |
| frm_valid | input | 1 | One-cycle strobe: a completed frame is presented |
| frm_opcode | input | 8 | Opcode of the frame |
| frm_has_addr | input | 1 | The frame carried three address bytes |
| frm_addr | input | 24 | Address received in the frame |
| frm_nbytes | input | 2 | Number of data bytes received (saturating at 3) |
| frm_byte0 | input | 8 | First data byte |
| frm_byte1 | input | 8 | Second data byte |
| mem_busy | input | 1 | Array programming in progress |
| prog_valid | output | 1 | Byte program request |
| prog_addr | output | 24 | Byte address of the request |
| prog_data | output | 8 | Byte to program |
| aai_active | output | 1 | Word-program mode is active |
| wel | output | 1 | Write-enable latch |
| so_oe | output | 1 | Drive the data-out pin with ready/busy |
| so_val | output | 1 | Ready/busy value (1 = ready) |

## Verification
On every cycle, the assertions check four things. An even-address request is always followed by the odd byte of the same word. The word address stays unchanged unless a frame is accepted. The mode is never active without write-enable. The data-out pin is driven only while chip-select is low and the mode is active. Some behaviours can only be shown by the directed scenarios: the exact byte addresses and data, the step of two between frames, wrap-around at the top of the address space, and which opcodes are ignored. The scenarios also cover frames dropped because the array is busy or the frame is short, and the exit through write-disable.

// File: rtl/aai_seq_pkg.sv
package aai_seq_pkg;
  localparam logic [7:0] OP_AAI   = 8'hAD;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_RB_ON = 8'h70;
  localparam logic [7:0] OP_RB_OFF = 8'h80;

  typedef struct packed {
    logic set_wel;
    logic clr_wel;
    logic enter;
    logic cont;
    logic leave;
    logic rb_on;
    logic rb_off;
  } seq_act_t;
endpackage

// File: rtl/aai_cmd_decode.sv
module aai_cmd_decode
  import aai_seq_pkg::*;
(
  input  logic       frm_valid,
  input  logic [7:0] frm_opcode,
  input  logic       frm_has_addr,
  input  logic [1:0] frm_nbytes,
  input  logic       mode_q,
  input  logic       wel_q,
  input  logic       hold,
  output seq_act_t   act
);
  logic pair_ok;
  assign pair_ok = (frm_nbytes == 2'd2);

  always_comb begin
    act = '0;
    if (frm_valid) begin
      if (mode_q) begin
        unique case (frm_opcode)
          OP_AAI:    act.cont = pair_ok && !hold;
          OP_WRDI: begin
            act.leave   = 1'b1;
            act.clr_wel = 1'b1;
          end
          OP_RB_ON:  act.rb_on  = 1'b1;
          OP_RB_OFF: act.rb_off = 1'b1;
          OP_RDSR:   act = '0;
          default:   act = '0;
        endcase
      end else begin
        unique case (frm_opcode)
          OP_WREN:   act.set_wel = 1'b1;
          OP_WRDI:   act.clr_wel = 1'b1;
          OP_RB_ON:  act.rb_on   = 1'b1;
          OP_RB_OFF: act.rb_off  = 1'b1;
          OP_AAI:    act.enter   = frm_has_addr && pair_ok && wel_q && !hold;
          default:   act = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/aai_addr_track.sv
module aai_addr_track #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter,
  input  logic          cont,
  input  logic [AW-1:0] frm_addr,
  output logic [AW-1:0] base
);
  localparam logic [AW-1:0] STEP = AW'(2);

  logic [AW-1:0] word_q, word_d;
  logic          adv;

  assign adv  = enter || cont;
  assign base = enter ? {frm_addr[AW-1:1], 1'b0} : word_q;

  always_comb begin
    word_d = word_q;
    if (adv) word_d = base + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (adv) word_q <= word_d;
  end

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(word_q));
endmodule

// File: rtl/aai_byte_issue.sv
module aai_byte_issue #(
  parameter int AW = 24,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] lo_byte,
  input  logic [DW-1:0] hi_byte,
  output logic          prog_valid,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic          issuing
);
  logic          vld_q, vld_d;
  logic          pend_q, pend_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic [DW-1:0] hi_q, hi_d;
  logic          step_en;

  assign step_en = load || pend_q || vld_q;

  always_comb begin
    vld_d  = 1'b0;
    pend_d = 1'b0;
    addr_d = addr_q;
    data_d = data_q;
    hi_d   = hi_q;
    if (load) begin
      vld_d  = 1'b1;
      pend_d = 1'b1;
      addr_d = {base[AW-1:1], 1'b0};
      data_d = lo_byte;
      hi_d   = hi_byte;
    end else if (pend_q) begin
      vld_d  = 1'b1;
      addr_d = {addr_q[AW-1:1], 1'b1};
      data_d = hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      hi_q   <= '0;
    end else if (step_en) begin
      vld_q  <= vld_d;
      pend_q <= pend_d;
      addr_q <= addr_d;
      data_q <= data_d;
      hi_q   <= hi_d;
    end
  end

  assign prog_valid = vld_q;
  assign prog_addr  = addr_q;
  assign prog_data  = data_q;
  assign issuing    = vld_q || pend_q;

  // R4
  odd_follows_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && !prog_addr[0]) |=>
      (prog_valid && prog_addr[0] && prog_addr[AW-1:1] == $past(prog_addr[AW-1:1])));
endmodule

// File: rtl/aai_rb_drive.sv
module aai_rb_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_en,
  input  logic mode,
  input  logic cs_n,
  input  logic rd_active,
  input  logic busy,
  output logic so_oe,
  output logic so_val
);
  assign so_oe  = rb_en && mode && !cs_n && !rd_active;
  assign so_val = !busy;

  // R10
  so_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (!cs_n && mode && !rd_active));
endmodule

// File: rtl/aai_word_prog_seq.sv
module aai_word_prog_seq
  import aai_seq_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_active,
  input  logic          frm_valid,
  input  logic [7:0]    frm_opcode,
  input  logic          frm_has_addr,
  input  logic [AW-1:0] frm_addr,
  input  logic [1:0]    frm_nbytes,
  input  logic [DW-1:0] frm_byte0,
  input  logic [DW-1:0] frm_byte1,
  input  logic          mem_busy,
  output logic          prog_valid,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic          aai_active,
  output logic          wel,
  output logic          so_oe,
  output logic          so_val
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_act_t act;
  logic     mode_q, mode_d;
  logic     wel_q, wel_d;
  logic     rb_q, rb_d;
  logic     issuing;
  logic     hold;
  logic [AW-1:0] base;

  assign hold = mem_busy || issuing;

  aai_cmd_decode u_dec (
    .frm_valid    (frm_valid),
    .frm_opcode   (frm_opcode),
    .frm_has_addr (frm_has_addr),
    .frm_nbytes   (frm_nbytes),
    .mode_q       (mode_q),
    .wel_q        (wel_q),
    .hold         (hold),
    .act          (act)
  );

  always_comb begin
    mode_d = mode_q;
    wel_d  = wel_q;
    rb_d   = rb_q;
    if (act.enter)   mode_d = 1'b1;
    if (act.leave)   mode_d = 1'b0;
    if (act.set_wel) wel_d  = 1'b1;
    if (act.clr_wel) wel_d  = 1'b0;
    if (act.rb_on)   rb_d   = 1'b1;
    if (act.rb_off)  rb_d   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= 1'b0;
      wel_q  <= 1'b0;
      rb_q   <= 1'b0;
    end else if (frm_valid) begin
      mode_q <= mode_d;
      wel_q  <= wel_d;
      rb_q   <= rb_d;
    end
  end

  aai_addr_track #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .enter    (act.enter),
    .cont     (act.cont),
    .frm_addr (frm_addr),
    .base     (base)
  );

  aai_byte_issue #(.AW(AW), .DW(DW)) u_issue (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (act.enter || act.cont),
    .base       (base),
    .lo_byte    (frm_byte0),
    .hi_byte    (frm_byte1),
    .prog_valid (prog_valid),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .issuing    (issuing)
  );

  aai_rb_drive u_rb (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rb_en     (rb_q),
    .mode      (mode_q),
    .cs_n      (cs_n),
    .rd_active (rd_active),
    .busy      (hold),
    .so_oe     (so_oe),
    .so_val    (so_val)
  );

  assign aai_active = mode_q;
  assign wel        = wel_q;

  // R3 R8
  mode_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mode_q |-> wel_q);

  // R8
  exit_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(mode_q) |-> !wel_q);
endmodule

// File: tb/aai_word_prog_seq_test.sv
module aai_word_prog_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        rd_active = 1'b0;
  logic        frm_valid = 1'b0;
  logic [7:0]  frm_opcode = '0;
  logic        frm_has_addr = 1'b0;
  logic [23:0] frm_addr = '0;
  logic [1:0]  frm_nbytes = '0;
  logic [7:0]  frm_byte0 = '0;
  logic [7:0]  frm_byte1 = '0;
  logic        mem_busy = 1'b0;
  logic        prog_valid;
  logic [23:0] prog_addr;
  logic [7:0]  prog_data;
  logic        aai_active, wel, so_oe, so_val;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  aai_word_prog_seq uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_active(rd_active),
    .frm_valid(frm_valid), .frm_opcode(frm_opcode), .frm_has_addr(frm_has_addr),
    .frm_addr(frm_addr), .frm_nbytes(frm_nbytes), .frm_byte0(frm_byte0),
    .frm_byte1(frm_byte1), .mem_busy(mem_busy), .prog_valid(prog_valid),
    .prog_addr(prog_addr), .prog_data(prog_data), .aai_active(aai_active),
    .wel(wel), .so_oe(so_oe), .so_val(so_val)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Present one frame; check the two request beats and the idle cycle after.
  task automatic frame(input string req, input logic [7:0] op, input logic ha,
                       input logic [23:0] a, input logic [1:0] nb,
                       input logic [7:0] d0, input logic [7:0] d1,
                       input logic exp_req, input logic [23:0] exp_word);
    @(negedge clk);
    frm_valid = 1'b1; frm_opcode = op; frm_has_addr = ha; frm_addr = a;
    frm_nbytes = nb; frm_byte0 = d0; frm_byte1 = d1;
    @(negedge clk);
    frm_valid = 1'b0;
    chk(req, {31'd0, prog_valid}, {31'd0, exp_req});
    if (exp_req) begin
      chk(req, {8'd0, prog_addr}, {8'd0, exp_word[23:1], 1'b0});
      chk(req, {24'd0, prog_data}, {24'd0, d0});
    end
    @(negedge clk);
    chk(req, {31'd0, prog_valid}, {31'd0, exp_req});
    if (exp_req) begin
      chk(req, {8'd0, prog_addr}, {8'd0, exp_word[23:1], 1'b1});
      chk(req, {24'd0, prog_data}, {24'd0, d1});
    end
    @(negedge clk);
    chk(req, {31'd0, prog_valid}, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 aai", {31'd0, aai_active}, 0);
    chk("R1 wel", {31'd0, wel}, 0);
    chk("R1 valid", {31'd0, prog_valid}, 0);
    cs_n = 1'b0;
    @(negedge clk);
    chk("R1 so_oe", {31'd0, so_oe}, 0);
    cs_n = 1'b1;
  endtask

  task automatic t_wel;
    frame("R3 no wel", 8'hAD, 1, 24'h000100, 2, 8'h11, 8'h22, 0, 0);
    chk("R3 stays idle", {31'd0, aai_active}, 0);
    frame("R2 wren", 8'h06, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 set", {31'd0, wel}, 1);
    frame("R2 wrdi", 8'h04, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 clear", {31'd0, wel}, 0);
    frame("R2 wren", 8'h06, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_entry;
    frame("R4 entry", 8'hAD, 1, 24'h001235, 2, 8'hA1, 8'hB2, 1, 24'h001234);
    chk("R3 active", {31'd0, aai_active}, 1);
    frame("R5 cont", 8'hAD, 1, 24'hFFFFFF, 2, 8'hC3, 8'hD4, 1, 24'h001236);
  endtask

  task automatic t_short_busy;
    frame("R11 short", 8'hAD, 0, 0, 1, 8'h55, 8'h66, 0, 0);
    mem_busy = 1'b1;
    frame("R6 busy", 8'hAD, 0, 0, 2, 8'h77, 8'h88, 0, 0);
    mem_busy = 1'b0;
    frame("R6 after busy", 8'hAD, 0, 0, 2, 8'h99, 8'hAA, 1, 24'h001238);
  endtask

  task automatic t_ignored;
    frame("R7 wren", 8'h06, 0, 0, 0, 0, 0, 0, 0);
    frame("R7 erase", 8'h20, 1, 24'h000000, 0, 0, 0, 0, 0);
    frame("R7 rdsr", 8'h05, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 mode kept", {31'd0, aai_active}, 1);
    chk("R7 wel kept", {31'd0, wel}, 1);
    frame("R7 next", 8'hAD, 0, 0, 2, 8'hBB, 8'hCC, 1, 24'h00123A);
  endtask

  task automatic t_rb;
    cs_n = 1'b0;
    @(negedge clk);
    chk("R10 off", {31'd0, so_oe}, 0);
    frame("R9 on", 8'h70, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 oe", {31'd0, so_oe}, 1);
    chk("R10 ready", {31'd0, so_val}, 1);
    mem_busy = 1'b1;
    @(negedge clk);
    chk("R10 busy", {31'd0, so_val}, 0);
    rd_active = 1'b1;
    @(negedge clk);
    chk("R10 read", {31'd0, so_oe}, 0);
    rd_active = 1'b0; mem_busy = 1'b0; cs_n = 1'b1;
    @(negedge clk);
    chk("R10 cs high", {31'd0, so_oe}, 0);
    cs_n = 1'b0;
    frame("R9 off", 8'h80, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 oe off", {31'd0, so_oe}, 0);
    cs_n = 1'b1;
  endtask

  task automatic t_exit;
    frame("R8 wrdi", 8'h04, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 exit", {31'd0, aai_active}, 0);
    chk("R8 wel", {31'd0, wel}, 0);
    frame("R8 after", 8'hAD, 0, 0, 2, 8'h12, 8'h34, 0, 0);
  endtask

  task automatic t_wrap;
    frame("R5 wren", 8'h06, 0, 0, 0, 0, 0, 0, 0);
    frame("R5 top", 8'hAD, 1, 24'hFFFFFE, 2, 8'hE1, 8'hE2, 1, 24'hFFFFFE);
    frame("R5 wrap", 8'hAD, 0, 0, 2, 8'hF1, 8'hF2, 1, 24'h000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_wel();
    t_entry();
    t_short_busy();
    t_ignored();
    t_rb();
    t_exit();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule